// File: doc/BRIEF.md
# Dual-Channel Burst Capture Engine

This block is a small built-in oscilloscope. Two 14-bit converter channels arrive together with one shared valid strobe. Once armed, the engine writes channel pairs into an on-chip buffer. Each buffer entry holds both channels taken on the same valid cycle. A capture is a finite burst of a programmed number of points, at most the buffer depth. The depth is a parameter with a default of 1024 and a ceiling of 16384. When the last point is written, the engine raises a done flag and stops writing.

A runtime decimation factor N makes the engine keep only one of every N valid converter samples. The capture window is therefore depth × N × sample period. A larger N gives a longer record at a coarser time step without any extra storage.

After done is set, the host reads entries back one word at a time through an address port, with one cycle of latency. A new arm command clears done and starts a fresh capture at address 0.

Top module: `twin_burst_capture`

## Requirements
- R1: After reset, `doneFlag` is 0, `rdValid` is 0 and `rdData` is 0.
- R2: Each stored entry holds channel A in bits [27:14] and channel B in bits [13:0], both taken from the same valid cycle.
- R3: After an accepted arm, the engine stores exactly the programmed number of points at addresses 0, 1, 2, … in arrival order. `doneFlag` is high from the clock edge that writes the last point. Samples after that point overwrite nothing.
- R4: With decimation N, the engine stores the 1st, (N+1)th, (2N+1)th, … valid samples after arming. An `cfgDecim` value of 0 behaves as N = 1.
- R5: The decimation count restarts at every accepted arm, so the first valid sample after arming is always stored, whatever the previous capture left behind.
- R6: `armPulse` while a capture is running is ignored. The running capture keeps its length, decimation and write address.
- R7: An arm while idle or done clears `doneFlag` at the next edge and restarts writing at address 0.
- R8: One edge after `rdAddr` is presented, `rdValid` equals the `doneFlag` value at that edge. `rdData` then holds the entry at that address when valid, and 0 otherwise.
- R9: A `cfgLength` of 0 captures 1 point. A `cfgLength` above DEPTH captures DEPTH points.
- R10: Cycles with `smpValid` low neither store anything nor advance the decimation count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smpValid | input | 1 | Both channel words are valid this cycle |
| smpChA | input | 14 | Channel A sample |
| smpChB | input | 14 | Channel B sample |
| armPulse | input | 1 | One-cycle arm command |
| cfgDecim | input | DECIM_W | Decimation factor N, latched at arm (0 acts as 1) |
| cfgLength | input | clog2(DEPTH+1) | Points to capture, latched at arm |
| rdAddr | input | clog2(DEPTH) | Readout word address |
| doneFlag | output | 1 | Capture complete; buffer readable |
| rdValid | output | 1 | rdData is valid |
| rdData | output | 28 | Channel pair {A, B} at the requested address |

## Verification
A valid sample presented before an edge is written at that edge. For the final point, `doneFlag` rises at that same edge. An arm takes effect one edge after it is presented, and readout data appears one edge after the address. The bench drives every input on the falling clock edge and samples every output on the following falling edge. Each result is therefore read exactly one rising edge after its cause. Counting tests check `doneFlag` one sample before the last point, where it must still be low, and again right after it, where it must be high.

// File: rtl/burst_cap_pkg.sv
package burst_cap_pkg;

  localparam int SMP_W  = 14;
  localparam int PAIR_W = 2 * SMP_W;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_DONE = 2'd2
  } capState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic addrClr;  // restart write address at 0
    logic wrEn;     // store current channel pair
    logic rdEn;     // readout permitted
  } capStrobe_t;

endpackage

// File: rtl/burst_cap_ctrl.sv
module burst_cap_ctrl
  import burst_cap_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int DECIM_W = 16,
  parameter int AW      = $clog2(DEPTH),
  parameter int LEN_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armPulse,
  input  logic               smpValid,
  input  logic [DECIM_W-1:0] cfgDecim,
  input  logic [LEN_W-1:0]   cfgLength,
  input  logic [AW-1:0]      wrAddr,
  output capStrobe_t         strobe,
  output logic               doneFlag,
  output logic               runActive
);

  capState_e          state;
  logic [DECIM_W-1:0] decimCnt;
  logic [DECIM_W-1:0] decimLast;
  logic [AW-1:0]      lenLast;
  logic [DECIM_W-1:0] decimLastNext;
  logic [AW-1:0]      lenLastNext;
  logic               armAccept;
  logic               take;
  logic               lastWrite;

  // Decimation N-1; a zero setting behaves as N = 1
  always_comb begin
    if (cfgDecim == '0) decimLastNext = '0;
    else                decimLastNext = cfgDecim - DECIM_W'(1);
  end

  // Length clamped to 1..DEPTH, held as the last address
  always_comb begin
    if (cfgLength == '0)                 lenLastNext = '0;
    else if (cfgLength > LEN_W'(DEPTH))  lenLastNext = AW'(DEPTH - 1);
    else                                 lenLastNext = AW'(cfgLength - LEN_W'(1));
  end

  assign armAccept = armPulse && (state != CAP_RUN);
  assign take      = (state == CAP_RUN) && smpValid && (decimCnt == '0);
  assign lastWrite = take && (wrAddr == lenLast);

  always_comb begin
    strobe         = '0;
    strobe.addrClr = armAccept;
    strobe.wrEn    = take;
    strobe.rdEn    = (state == CAP_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= CAP_IDLE;
      decimCnt  <= '0;
      decimLast <= '0;
      lenLast   <= '0;
    end else if (armAccept) begin
      state     <= CAP_RUN;
      decimCnt  <= '0;
      decimLast <= decimLastNext;
      lenLast   <= lenLastNext;
    end else if (state == CAP_RUN) begin
      if (smpValid) begin
        if (decimCnt == decimLast) decimCnt <= '0;
        else                       decimCnt <= decimCnt + DECIM_W'(1);
      end
      if (lastWrite) state <= CAP_DONE;
    end
  end

  assign doneFlag  = (state == CAP_DONE);
  assign runActive = (state == CAP_RUN);

endmodule

// File: rtl/burst_cap_dpath.sv
module burst_cap_dpath
  import burst_cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [SMP_W-1:0]  smpChA,
  input  logic [SMP_W-1:0]  smpChB,
  input  logic [AW-1:0]     rdAddr,
  output logic [AW-1:0]     wrAddr,
  output logic [PAIR_W-1:0] rdData,
  output logic              rdValid
);

  localparam int NUM_CH = 2;

  logic [SMP_W-1:0]  chLane [NUM_CH];
  logic [PAIR_W-1:0] pairWord;
  logic [PAIR_W-1:0] mem [DEPTH];

  assign chLane[0] = smpChA;
  assign chLane[1] = smpChB;

  // Lane 0 in the upper slice, the last lane in the lowest
  for (genvar g = 0; g < NUM_CH; g++) begin : g_pack
    assign pairWord[(NUM_CH-g)*SMP_W-1 -: SMP_W] = chLane[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               wrAddr <= '0;
    else if (strobe.addrClr) wrAddr <= '0;
    else if (strobe.wrEn)    wrAddr <= wrAddr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= pairWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      rdData  <= strobe.rdEn ? mem[rdAddr] : '0;
    end
  end

endmodule

// File: rtl/twin_burst_capture.sv
module twin_burst_capture
  import burst_cap_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int DECIM_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          smpValid,
  input  logic [13:0]                   smpChA,
  input  logic [13:0]                   smpChB,
  input  logic                          armPulse,
  input  logic [DECIM_W-1:0]            cfgDecim,
  input  logic [$clog2(DEPTH+1)-1:0]    cfgLength,
  input  logic [$clog2(DEPTH)-1:0]      rdAddr,
  output logic                          doneFlag,
  output logic                          rdValid,
  output logic [27:0]                   rdData
);

  localparam int AW    = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  capStrobe_t    capStrobe;
  logic [AW-1:0] wrAddr;
  logic          runActive;

  burst_cap_ctrl #(
    .DEPTH(DEPTH), .DECIM_W(DECIM_W), .AW(AW), .LEN_W(LEN_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .smpValid(smpValid),
    .cfgDecim(cfgDecim), .cfgLength(cfgLength), .wrAddr(wrAddr),
    .strobe(capStrobe), .doneFlag(doneFlag), .runActive(runActive)
  );

  burst_cap_dpath #(
    .DEPTH(DEPTH), .AW(AW)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(capStrobe), .smpChA(smpChA),
    .smpChB(smpChB), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/burst_cap_chk.sv
module burst_cap_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          armPulse,
  input logic          smpValid,
  input logic          doneFlag,
  input logic          rdValid,
  input logic          runActive,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr
);

  AST_NO_WRITE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !wrEn) else $error("write while done");                       // R3

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !armPulse |=> doneFlag) else $error("done dropped");             // R3

  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> smpValid) else $error("write without valid");                      // R10

  AST_RUN_ARM_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    runActive && armPulse && !wrEn |=> $stable(wrAddr)) else $error("arm disturbed run"); // R6

  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && armPulse |=> !doneFlag && wrAddr == '0) else $error("rearm failed"); // R7

  AST_RD_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> rdValid) else $error("readout not valid");                     // R8

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !doneFlag |=> !rdValid) else $error("readout valid early");                 // R8

endmodule

bind twin_burst_capture burst_cap_chk #(.AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .armPulse(armPulse), .smpValid(smpValid),
  .doneFlag(doneFlag), .rdValid(rdValid), .runActive(runActive),
  .wrEn(capStrobe.wrEn), .wrAddr(wrAddr)
);

// File: tb/twin_burst_capture_tb_top.sv
module twin_burst_capture_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DECIM_W    = 8;
  localparam int AW         = $clog2(DEPTH);
  localparam int LEN_W      = $clog2(DEPTH + 1);
  localparam int WATCHDOG   = 50000;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               smpValid = 1'b0;
  logic [13:0]        smpChA = '0;
  logic [13:0]        smpChB = '0;
  logic               armPulse = 1'b0;
  logic [DECIM_W-1:0] cfgDecim = '0;
  logic [LEN_W-1:0]   cfgLength = '0;
  logic [AW-1:0]      rdAddr = '0;
  logic               doneFlag;
  logic               rdValid;
  logic [27:0]        rdData;

  int chkTotal = 0;
  int chkFail  = 0;
  int cycCnt   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_burst_capture #(.DEPTH(DEPTH), .DECIM_W(DECIM_W)) dut_i (
    .clk(clk), .rstN(rstN), .smpValid(smpValid), .smpChA(smpChA),
    .smpChB(smpChB), .armPulse(armPulse), .cfgDecim(cfgDecim),
    .cfgLength(cfgLength), .rdAddr(rdAddr), .doneFlag(doneFlag),
    .rdValid(rdValid), .rdData(rdData)
  );

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > WATCHDOG) begin
      chkTotal++;
      chkFail++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycCnt, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", chkTotal, chkFail);
      $finish;
    end
  end

  function automatic logic [13:0] valA(int n);
    return 14'(n * 37 + 5);
  endfunction

  function automatic logic [13:0] valB(int n);
    return 14'((n * 91) ^ 'h1555);
  endfunction

  function automatic logic [27:0] pairOf(int n);
    return {valA(n), valB(n)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    chkTotal++;
    if (act !== exp) begin
      chkFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic armCap(int decim, int len);
    @(negedge clk);
    cfgDecim  = DECIM_W'(decim);
    cfgLength = LEN_W'(len);
    armPulse  = 1'b1;
    @(negedge clk);
    armPulse  = 1'b0;
  endtask

  // Sample indices base .. base+count-1, optionally with idle gaps
  task automatic feed(int base, int count, bit gaps);
    for (int i = 0; i < count; i++) begin
      smpValid = 1'b1;
      smpChA   = valA(base + i);
      smpChB   = valB(base + i);
      @(negedge clk);
      if (gaps) begin
        smpValid = 1'b0;
        smpChA   = '1;
        smpChB   = '1;
        @(negedge clk);
      end
    end
    smpValid = 1'b0;
  endtask

  task automatic readAt(int addr, output logic [27:0] d, output logic v);
    rdAddr = AW'(addr);
    @(negedge clk);
    d = rdData;
    v = rdValid;
  endtask

  task automatic expectEntry(string req, int addr, int sampleIdx);
    logic [27:0] d;
    logic        v;
    readAt(addr, d, v);
    check(req, 32'(v), 32'd1);
    check(req, 32'(d), 32'(pairOf(sampleIdx)));
  endtask

  task automatic testReset();
    check("R1 done", 32'(doneFlag), 0);
    check("R1 rdValid", 32'(rdValid), 0);
    check("R1 rdData", 32'(rdData), 0);
  endtask

  task automatic testBasic();
    logic [27:0] d;
    logic        v;
    armCap(1, 8);
    feed(100, 7, 0);
    check("R3 done before last", 32'(doneFlag), 0);
    readAt(0, d, v);
    check("R8 valid while running", 32'(v), 0);
    check("R8 data zero while running", 32'(d), 0);
    feed(107, 1, 0);
    check("R3 done at last", 32'(doneFlag), 1);
    feed(108, 4, 0);
    check("R3 done holds", 32'(doneFlag), 1);
    for (int a = 0; a < 8; a++) expectEntry("R2 R3 entry", a, 100 + a);
  endtask

  task automatic testDecim();
    armCap(3, 5);
    feed(200, 12, 1);
    check("R4 done before 13th", 32'(doneFlag), 0);
    feed(212, 3, 1);
    check("R4 R10 done", 32'(doneFlag), 1);
    for (int a = 0; a < 5; a++) expectEntry("R4 R10 entry", a, 200 + 3 * a);
  endtask

  task automatic testDecimZero();
    armCap(0, 4);
    feed(300, 4, 0);
    check("R4 zero decim done", 32'(doneFlag), 1);
    for (int a = 0; a < 4; a++) expectEntry("R4 zero decim entry", a, 300 + a);
  endtask

  task automatic testArmDuringRun();
    armCap(1, 6);
    feed(400, 3, 0);
    armCap(4, 2);
    feed(403, 1, 0);
    check("R6 length kept", 32'(doneFlag), 0);
    feed(404, 2, 0);
    check("R6 done at original length", 32'(doneFlag), 1);
    for (int a = 0; a < 6; a++) expectEntry("R6 entry", a, 400 + a);
  endtask

  task automatic testRearm();
    armCap(1, 3);
    check("R7 done cleared", 32'(doneFlag), 0);
    feed(500, 3, 0);
    check("R7 done again", 32'(doneFlag), 1);
    expectEntry("R7 restart at zero", 0, 500);
    expectEntry("R7 second entry", 1, 501);
  endtask

  task automatic testDecimRestart();
    armCap(4, 1);
    feed(600, 1, 0);
    check("R5 setup done", 32'(doneFlag), 1);
    armCap(4, 2);
    feed(610, 5, 0);
    check("R5 done", 32'(doneFlag), 1);
    expectEntry("R5 first sample stored", 0, 610);
    expectEntry("R5 fifth sample stored", 1, 614);
  endtask

  task automatic testClamp();
    armCap(1, 0);
    feed(700, 1, 0);
    check("R9 zero length gives one", 32'(doneFlag), 1);
    expectEntry("R9 single entry", 0, 700);
    armCap(1, 31);
    feed(800, DEPTH - 1, 0);
    check("R9 before depth", 32'(doneFlag), 0);
    feed(800 + DEPTH - 1, 1, 0);
    check("R9 done at depth", 32'(doneFlag), 1);
    expectEntry("R9 first", 0, 800);
    expectEntry("R9 last", DEPTH - 1, 800 + DEPTH - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testDecim();
    testDecimZero();
    testArmDuringRun();
    testRearm();
    testDecimRestart();
    testClamp();
    $display("End of test - %0d assertions evaluated, %0d failures", chkTotal, chkFail);
    $finish;
  end

endmodule